// File: doc/BRIEF.md
# Two-Tone Sine-Table Bit Synthesizer

This block turns a serial bit stream into a stream of signed 16-bit samples for a DAC. Each bit is sent as exactly one of two tones. The "mark" tone carries a 1 and the "space" tone carries a 0. Both tones come from one stored sine period of 656 points. A read phase walks through that period by a whole-number step on every sample strobe, so each tone is set entirely by its step value. There is no fractional accumulator. The table length is picked so that the usual tone pairs (for example 72/81.6, 67.2/76.8 or 52.8/62.4 kHz at a 9.6 kbit/s bit rate) all land on integer steps. With those pairs each bit spans a whole number of samples, and the two tones stay orthogonal over one bit.

An external timing source supplies a sample strobe and a bit strobe. A bit boundary is a sample strobe that coincides with the bit strobe. At a boundary the block takes the pending bit through a valid/acknowledge handshake and loads that bit's step from one of two programmable step inputs. The phase is never cleared between bits, so the waveform stays phase-continuous. When no bit is offered at a boundary, the output falls to zero and an idle flag rises until a later boundary finds a bit.

Only a quarter period is stored. The other three quarters are rebuilt by mirroring the address and negating the sample.

Top module: `sfsk_dds_tx`

## Requirements
- R1: While reset is asserted, dac_smp is 0, dac_vld is 0, idle is 1, and the phase returns to 0.
- R2: dac_vld pulses high for exactly one cycle, in the cycle after each cycle with smp_stb high, and is low otherwise.
- R3: bit_ack is high in a cycle if and only if smp_stb, bit_stb and bit_vld are all high in that cycle. The bit on bit_dat is consumed in that cycle.
- R4: A consumed bit of 1 selects step_mark and a bit of 0 selects step_space, sampled at the boundary. A change on either step input between boundaries has no effect on the output until the next boundary.
- R5: While a tone is active, each sample equals round(32767 * sin(2*pi*k/656)), where k is the phase before this sample's advance and rounding is half away from zero. Each sample appears on dac_smp in the cycle after its strobe.
- R6: The phase starts at 0 after reset. While a tone is active it advances by the current step on each sample strobe. It is never cleared at a bit boundary, so consecutive bits continue from the phase left by the previous bit.
- R7: At a boundary with no bit offered, the sample is 0 and idle goes to 1. Both last until a boundary takes a bit. The phase is held meanwhile, and output resumes from the held phase.
- R8: Step values lie in 0..655. The phase wraps modulo 656 with a single subtraction, including with the largest step, 655.
- R9: bit_stb high while smp_stb is low is not a boundary. It produces no acknowledge, no sample and no change of tone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle strobe: produce one sample |
| bit_stb | input | 1 | Marks the sample strobe that starts a new bit |
| bit_vld | input | 1 | A bit is pending on bit_dat |
| bit_dat | input | 1 | Pending bit value |
| bit_ack | output | 1 | Pending bit consumed this cycle |
| step_mark | input | 10 | Phase step used for a 1 bit |
| step_space | input | 10 | Phase step used for a 0 bit |
| dac_smp | output | 16 | Signed sample to the DAC |
| dac_vld | output | 1 | dac_smp holds a new sample |
| idle | output | 1 | No bit is being sent; sample forced to 0 |

## Verification
Three situations are hard to reach from the ports.

The first is a step register that is rewritten in the middle of a bit. The stimulus writes a new mark step between boundaries of a 1 bit, and the scoreboard model keeps the step it latched, so any early pickup shows up as a wrong phase on the next sample.

The second is phase wrap with the widest steps. The stimulus runs steps 655 and 329, which force a subtraction on almost every sample and walk the phase across all four mirrored quarters.

The third is continuity across idle gaps and stray bit strobes. A boundary without a bit is inserted mid-stream, and the samples that follow are checked against the held phase. A bit strobe that arrives without a sample strobe must leave the tone alone.

// File: rtl/sfsk_pkg.sv
`timescale 1ns/1ps
package sfsk_pkg;

  // Which quarter of the sine period a phase falls in.
  typedef enum logic [1:0] {
    QD_RISE  = 2'd0,
    QD_FALL  = 2'd1,
    QD_NRISE = 2'd2,
    QD_NFALL = 2'd3
  } quad_e;

  // Modulo add for operands already below the modulus: one conditional subtract.
  function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned modn);
    int unsigned s;
    s = a + b;
    if (s >= modn) s = s - modn;
    return s;
  endfunction

  // Sine code for point k of an n-point period, rounded half away from zero.
  function automatic int qsin_code(int k, int n, int amp);
    real r;
    r = amp * $sin(2.0 * 3.14159265358979323846 * k / n);
    if (r >= 0.0) return $rtoi(r + 0.5);
    else          return -$rtoi(0.5 - r);
  endfunction

endpackage

// File: rtl/sfsk_sine_rom.sv
`timescale 1ns/1ps
module sfsk_sine_rom
  import sfsk_pkg::*;
#(
  parameter int unsigned QLEN  = 164,
  parameter int unsigned SMP_W = 16,
  parameter int unsigned AMP   = 32767,
  localparam int unsigned AW   = $clog2(QLEN + 1)
) (
  input  logic [AW-1:0]           addr,
  output logic signed [SMP_W-1:0] mag
);

  // Quarter period plus its end point: entries 0..QLEN.
  logic signed [SMP_W-1:0] tbl [QLEN+1];

  for (genvar g = 0; g <= int'(QLEN); g++) begin : g_ent
    localparam int CODE = qsin_code(g, int'(4 * QLEN), int'(AMP));
    assign tbl[g] = SMP_W'(CODE);
  end

  always_comb begin
    if (32'(addr) <= QLEN) mag = tbl[addr];
    else                   mag = '0;
  end

endmodule

// File: rtl/sfsk_wave_map.sv
`timescale 1ns/1ps
module sfsk_wave_map
  import sfsk_pkg::*;
#(
  parameter int unsigned TBL_LEN = 656,
  parameter int unsigned SMP_W   = 16,
  parameter int unsigned AMP     = 32767,
  localparam int unsigned QLEN   = TBL_LEN / 4,
  localparam int unsigned AW     = $clog2(QLEN + 1),
  localparam int unsigned IDX_W  = $clog2(TBL_LEN)
) (
  input  logic [IDX_W-1:0]        phase,
  output logic signed [SMP_W-1:0] wave
);

  typedef struct packed {
    quad_e         quad;
    logic [AW-1:0] addr;
  } fold_t;

  // Map a full-period phase onto the stored quarter and a sign.
  function automatic fold_t fold_idx(input logic [IDX_W-1:0] p);
    fold_t f;
    int unsigned pv;
    pv = 32'(p);
    if (pv <= QLEN) begin
      f.quad = QD_RISE;  f.addr = AW'(pv);
    end else if (pv <= 2 * QLEN) begin
      f.quad = QD_FALL;  f.addr = AW'(2 * QLEN - pv);
    end else if (pv <= 3 * QLEN) begin
      f.quad = QD_NRISE; f.addr = AW'(pv - 2 * QLEN);
    end else begin
      f.quad = QD_NFALL; f.addr = AW'(4 * QLEN - pv);
    end
    return f;
  endfunction

  fold_t                   fold;
  logic signed [SMP_W-1:0] mag;

  always_comb fold = fold_idx(phase);

  sfsk_sine_rom #(
    .QLEN (QLEN),
    .SMP_W(SMP_W),
    .AMP  (AMP)
  ) u_rom (
    .addr(fold.addr),
    .mag (mag)
  );

  always_comb begin
    unique case (fold.quad)
      QD_RISE, QD_FALL:   wave = mag;
      QD_NRISE, QD_NFALL: wave = -mag;
    endcase
  end

endmodule

// File: rtl/sfsk_phase_ctrl.sv
`timescale 1ns/1ps
module sfsk_phase_ctrl
  import sfsk_pkg::*;
#(
  parameter int unsigned TBL_LEN = 656,
  localparam int unsigned IDX_W  = $clog2(TBL_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic             bit_stb,
  input  logic             bit_vld,
  input  logic             bit_dat,
  input  logic [IDX_W-1:0] step_mark,
  input  logic [IDX_W-1:0] step_space,
  output logic             bit_ack,
  output logic [IDX_W-1:0] phase,
  output logic             tone_on_nxt
);

  logic [IDX_W-1:0] phase_q, phase_nxt;
  logic [IDX_W-1:0] step_q, step_nxt, step_pick;
  logic             on_q;
  logic             bnd;
  logic             take;

  assign bnd       = smp_stb & bit_stb;
  assign take      = bnd & bit_vld;
  assign bit_ack   = take;
  assign step_pick = bit_dat ? step_mark : step_space;

  always_comb begin
    step_nxt    = step_q;
    tone_on_nxt = on_q;
    if (bnd) begin
      tone_on_nxt = bit_vld;
      if (bit_vld) step_nxt = step_pick;
    end
    if (tone_on_nxt) phase_nxt = IDX_W'(wrap_add(32'(phase_q), 32'(step_nxt), TBL_LEN));
    else             phase_nxt = phase_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      step_q  <= '0;
      on_q    <= 1'b0;
    end else if (smp_stb) begin
      phase_q <= phase_nxt;
      step_q  <= step_nxt;
      on_q    <= tone_on_nxt;
    end
  end

  assign phase = phase_q;

  // R8: the phase stays inside the table.
  a_r8_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(phase_q) < TBL_LEN);

  // R8: a step loaded at a boundary is within the table.
  a_r8_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> 32'(step_pick) < TBL_LEN);

  // R4: the latched step only moves at a boundary.
  a_r4_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(step_q));

  // R6: the phase only moves on a sample strobe.
  a_r6_phase_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(phase_q));

  // R9: a bit strobe without a sample strobe changes no tone state.
  a_r9_stray_bit_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !smp_stb) |=> ($stable(on_q) && $stable(step_q)));

  // R3: an acknowledged bit was offered.
  a_r3_ack_offered: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ack |-> (bit_vld && smp_stb && bit_stb));

endmodule

// File: rtl/sfsk_sample_reg.sv
`timescale 1ns/1ps
module sfsk_sample_reg #(
  parameter int unsigned SMP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_stb,
  input  logic                    tone_on_nxt,
  input  logic signed [SMP_W-1:0] wave,
  output logic signed [SMP_W-1:0] dac_smp,
  output logic                    dac_vld,
  output logic                    idle
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_smp <= '0;
      dac_vld <= 1'b0;
      idle    <= 1'b1;
    end else begin
      dac_vld <= smp_stb;
      if (smp_stb) begin
        dac_smp <= tone_on_nxt ? wave : '0;
        idle    <= !tone_on_nxt;
      end
    end
  end

  // R7: an idle output carries a zero sample.
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> dac_smp == '0);

  // R2: one valid pulse per strobe, one cycle later.
  a_r2_vld_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> dac_vld);

  a_r2_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> !dac_vld);

  // R2: the sample holds between strobes.
  a_r2_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(dac_smp));

endmodule

// File: rtl/sfsk_dds_tx.sv
`timescale 1ns/1ps
module sfsk_dds_tx #(
  parameter int unsigned TBL_LEN = 656,
  parameter int unsigned SMP_W   = 16,
  parameter int unsigned AMP     = 32767,
  localparam int unsigned IDX_W  = $clog2(TBL_LEN)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_stb,
  input  logic                    bit_stb,
  input  logic                    bit_vld,
  input  logic                    bit_dat,
  output logic                    bit_ack,
  input  logic [IDX_W-1:0]        step_mark,
  input  logic [IDX_W-1:0]        step_space,
  output logic signed [SMP_W-1:0] dac_smp,
  output logic                    dac_vld,
  output logic                    idle
);

  logic [IDX_W-1:0]        phase;
  logic                    tone_on_nxt;
  logic signed [SMP_W-1:0] wave;

  sfsk_phase_ctrl #(
    .TBL_LEN(TBL_LEN)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_stb    (smp_stb),
    .bit_stb    (bit_stb),
    .bit_vld    (bit_vld),
    .bit_dat    (bit_dat),
    .step_mark  (step_mark),
    .step_space (step_space),
    .bit_ack    (bit_ack),
    .phase      (phase),
    .tone_on_nxt(tone_on_nxt)
  );

  sfsk_wave_map #(
    .TBL_LEN(TBL_LEN),
    .SMP_W  (SMP_W),
    .AMP    (AMP)
  ) u_wave (
    .phase(phase),
    .wave (wave)
  );

  sfsk_sample_reg #(
    .SMP_W(SMP_W)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_stb    (smp_stb),
    .tone_on_nxt(tone_on_nxt),
    .wave       (wave),
    .dac_smp    (dac_smp),
    .dac_vld    (dac_vld),
    .idle       (idle)
  );

  // R7: an idle strobe leaves the phase where it was.
  a_r7_idle_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !tone_on_nxt) |=> $stable(phase));

  // R7: while idle with no boundary, no tone starts.
  a_r7_idle_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !(smp_stb && bit_stb)) |=> idle);

endmodule

// File: tb/sfsk_dds_tx_tb.sv
`timescale 1ns/1ps
module sfsk_dds_tx_tb_top;

  localparam int TBL = 656;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_stb = 1'b0;
  logic              bit_stb = 1'b0;
  logic              bit_vld = 1'b0;
  logic              bit_dat = 1'b0;
  logic [9:0]        step_mark = '0;
  logic [9:0]        step_space = '0;
  logic              bit_ack;
  logic signed [15:0] dac_smp;
  logic              dac_vld;
  logic              idle;

  always #10 clk = ~clk;   // 50 MHz

  sfsk_dds_tx dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_stb   (smp_stb),
    .bit_stb   (bit_stb),
    .bit_vld   (bit_vld),
    .bit_dat   (bit_dat),
    .bit_ack   (bit_ack),
    .step_mark (step_mark),
    .step_space(step_space),
    .dac_smp   (dac_smp),
    .dac_vld   (dac_vld),
    .idle      (idle)
  );

  typedef struct {
    int    smp;
    bit    idl;
    string req;
  } exp_t;

  exp_t expq[$];
  int   n_cmp = 0;
  int   n_bad = 0;

  // Reference model state
  int   m_phase = 0;
  int   m_step  = 0;
  bit   m_on    = 1'b0;

  function automatic int ref_sine(int k);
    real a;
    a = 32767.0 * $sin(6.283185307179586 * real'(k) / real'(TBL));
    if (a < 0.0) return -$rtoi(-a + 0.5);
    return $rtoi(a + 0.5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv, input string what);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Driver: one sample strobe; pushes the expected sample into the scoreboard.
  task automatic strobe(input bit at_bnd, input bit have, input bit b, input int gap, input string req);
    @(negedge clk);
    smp_stb = 1'b1;
    bit_stb = at_bnd;
    bit_vld = have;
    bit_dat = b;
    #1;
    chk(bit_ack == (at_bnd && have), "R3", int'(bit_ack), int'(at_bnd && have), "bit_ack");
    if (at_bnd) begin
      m_on = have;
      if (have) m_step = b ? int'(step_mark) : int'(step_space);
    end
    expq.push_back('{m_on ? ref_sine(m_phase) : 0, !m_on, req});
    if (m_on) m_phase = (m_phase + m_step) % TBL;
    @(posedge clk);
    #1;
    smp_stb = 1'b0;
    bit_stb = 1'b0;
    bit_vld = 1'b0;
    repeat (gap) @(posedge clk);
  endtask

  task automatic send_bit(input bit b, input int len, input string req);
    strobe(1'b1, 1'b1, b, 0, req);
    for (int j = 1; j < len; j++) strobe(1'b0, 1'b1, 1'b0, j % 3, req);
  endtask

  // Monitor: pop and compare each produced sample.
  always @(negedge clk) begin
    if (rst_n && dac_vld) begin
      exp_t e;
      int   d;
      if (expq.size() == 0) begin
        chk(1'b0, "R2", 1, 0, "dac_vld without strobe");
      end else begin
        e = expq.pop_front();
        d = int'(dac_smp) - e.smp;
        chk(d <= 1 && d >= -1, e.req, int'(dac_smp), e.smp, "sample");
        chk(idle == e.idl, "R7", int'(idle), int'(e.idl), "idle");
      end
    end
  end

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(dac_smp == 0, "R1", int'(dac_smp), 0, "dac_smp in reset");
    chk(dac_vld == 0, "R1", int'(dac_vld), 0, "dac_vld in reset");
    chk(idle == 1, "R1", int'(idle), 1, "idle in reset");
    chk(bit_ack == 0, "R1", int'(bit_ack), 0, "bit_ack in reset");
    rst_n = 1'b1;

    step_mark  = 10'd17;
    step_space = 10'd15;

    // R7: no bit yet, output idles at zero
    for (int i = 0; i < 3; i++) strobe(1'b0, 1'b0, 1'b0, 1, "R7");

    // R5, R6: alternating tones, phase carried across bits
    begin
      bit pat [5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
      for (int i = 0; i < 5; i++) send_bit(pat[i], 5, "R6");
    end

    // R4: mark step rewritten mid-bit takes effect only at the next boundary
    strobe(1'b1, 1'b1, 1'b1, 0, "R4");
    strobe(1'b0, 1'b0, 1'b0, 0, "R4");
    step_mark = 10'd400;
    strobe(1'b0, 1'b0, 1'b0, 1, "R4");
    strobe(1'b0, 1'b0, 1'b0, 0, "R4");
    send_bit(1'b1, 4, "R4");

    // R7: boundary with nothing offered, then resume from held phase
    strobe(1'b1, 1'b0, 1'b0, 0, "R7");
    strobe(1'b0, 1'b0, 1'b0, 2, "R7");
    strobe(1'b0, 1'b0, 1'b0, 0, "R7");
    send_bit(1'b0, 4, "R7");

    // R8: widest steps, wrap on nearly every sample
    step_mark  = 10'd655;
    step_space = 10'd329;
    begin
      bit pat2 [4] = '{1'b1, 1'b0, 1'b0, 1'b1};
      for (int i = 0; i < 4; i++) send_bit(pat2[i], 6, "R8");
    end

    // R9: bit strobe without sample strobe is no boundary
    @(negedge clk);
    bit_stb = 1'b1;
    bit_vld = 1'b1;
    bit_dat = 1'b0;
    #1;
    chk(bit_ack == 1'b0, "R9", int'(bit_ack), 0, "bit_ack on stray bit_stb");
    @(posedge clk);
    #1;
    bit_stb = 1'b0;
    bit_vld = 1'b0;
    for (int i = 0; i < 3; i++) strobe(1'b0, 1'b0, 1'b0, 0, "R9");

    // R5: one more tone at the first pair's space step
    step_space = 10'd15;
    send_bit(1'b0, 8, "R5");

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(expq.size() == 0, "R2", expq.size(), 0, "samples outstanding");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule